// File: doc/BRIEF.md
# Programmable LCD Timing Generator

This block produces the raster timing for a parallel RGB panel: horizontal sync, vertical sync, data enable, the current pixel and line positions, a line strobe, a frame strobe, and a static select for the pixel-clock launch edge. Every boundary on both axes is a programmed compare value. Both counters start at the leading edge of sync, so the back porch, the visible area and the front porch are simply windows placed later on each axis.

Software writes six words through a simple write port: configuration, horizontal sync, vertical sync, totals, horizontal display window and vertical display window. Writes land in a shadow set. The active set is copied from the shadow only at the frame boundary, so a frame always runs on one coherent set of values and reprogramming between frames never tears a frame.

Top module: `lcd_timing_gen`

## Requirements
- R1: Word addresses are 0 configuration, 1 horizontal sync, 2 vertical sync, 3 totals, 4 horizontal display, 5 vertical display. Each timing word carries a start field in bits [25:16] and an end field in bits [9:0]. The totals word holds the horizontal total in the start field and the vertical total in the end field. The start fields of the two sync words are ignored.
- R2: The horizontal counter `hcnt_o` runs 0, 1, … up to the horizontal total minus 1 and then returns to 0 (a total of 0 behaves as 1). `line_o` is high in the last cycle of each line.
- R3: The vertical counter `vcnt_o` advances by one only in the cycle after a line ends. It wraps under the same rule, using the vertical total. `frame_o` is high in the last cycle of the last line, and both counters read 0 in the cycle after it.
- R4: HSYNC is active while `hcnt_o` is below the horizontal sync end. VSYNC is active while `vcnt_o` is below the vertical sync end. An end value of 0 gives no pulse.
- R5: DE is active exactly when the horizontal display start ≤ `hcnt_o` < the horizontal display end and the vertical display start ≤ `vcnt_o` < the vertical display end. Starts are inclusive and ends are exclusive.
- R6: Configuration bit 11 makes HSYNC active-low, bit 8 makes VSYNC active-low and bit 9 makes DE active-low. When a bit is clear, that signal is active-high.
- R7: `pclk_fall_o` equals configuration bit 10 of the active set (1 means data launches on the falling pixel-clock edge).
- R8: A write changes no output until the frame boundary, which is the clock edge at which `frame_o` is high. From the next cycle on, the whole shadow set is in effect.
- R9: During and directly after reset, all registers are 0. The counters read 0, HSYNC, VSYNC, DE and `pclk_fall_o` are 0, and `line_o` and `frame_o` are 1, because a zero total makes every cycle a boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Word address of the write |
| wr_data_i | input | 32 | Write data |
| hsync_o | output | 1 | Horizontal sync at programmed polarity |
| vsync_o | output | 1 | Vertical sync at programmed polarity |
| de_o | output | 1 | Data enable at programmed polarity |
| pclk_fall_o | output | 1 | 1 = launch data on falling pixel-clock edge |
| hcnt_o | output | 10 | Current horizontal position |
| vcnt_o | output | 10 | Current vertical position |
| line_o | output | 1 | High in the last cycle of each line |
| frame_o | output | 1 | High in the last cycle of each frame |

## Verification
The two functions that can fall in the same cycle are a register write and the frame-boundary copy from shadow to active. The bench provokes this by writing a complete new set part-way through a running frame and then sweeping every cycle of that frame and the next. Each cycle's expected counters, strobes, syncs and DE are computed arithmetically from the configuration that should be active in that cycle. The test passes only if the old set holds to the last cycle of the frame and the new set holds from the first cycle after the boundary.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;
  localparam int ADDR_W = 3;
  localparam int NF     = 8;
  localparam int HI_LSB = 16;

  typedef enum logic [ADDR_W-1:0] {
    A_CFG = 3'd0, A_HSYNC = 3'd1, A_VSYNC = 3'd2,
    A_TOTAL = 3'd3, A_HDISP = 3'd4, A_VDISP = 3'd5
  } reg_addr_e;

  // field slots in the shadow/active arrays
  localparam int F_HSE = 0, F_VSE = 1, F_HT = 2, F_VT = 3;
  localparam int F_HDS = 4, F_HDE = 5, F_VDS = 6, F_VDE = 7;

  // config word bit positions
  localparam int B_VLOW = 8, B_DELOW = 9, B_PFALL = 10, B_HLOW = 11;
  // compacted config slots
  localparam int C_HLOW = 0, C_VLOW = 1, C_DELOW = 2, C_PFALL = 3;
endpackage

// File: rtl/lcd_tg_regs.sv
module lcd_tg_regs
  import lcd_tg_pkg::*;
#(
  parameter int CW = 10,
  parameter int DW = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [ADDR_W-1:0]      wr_addr_i,
  input  logic [DW-1:0]          wr_data_i,
  input  logic                   load_i,
  output logic [NF-1:0][CW-1:0]  fld_o,
  output logic [3:0]             cfg_o
);
  logic [NF-1:0][CW-1:0] sh_q, act_q;
  logic [3:0]            shc_q, actc_q;
  logic [CW-1:0]         hi, lo;
  logic                  unused_data;

  assign hi          = wr_data_i[HI_LSB +: CW];
  assign lo          = wr_data_i[0 +: CW];
  assign unused_data = ^wr_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      shc_q <= '0;
    end else if (wr_en_i) begin
      case (reg_addr_e'(wr_addr_i))
        A_CFG:   shc_q <= {wr_data_i[B_PFALL], wr_data_i[B_DELOW],
                           wr_data_i[B_VLOW], wr_data_i[B_HLOW]};
        A_HSYNC: sh_q[F_HSE] <= lo;
        A_VSYNC: sh_q[F_VSE] <= lo;
        A_TOTAL: begin sh_q[F_HT] <= hi; sh_q[F_VT] <= lo; end
        A_HDISP: begin sh_q[F_HDS] <= hi; sh_q[F_HDE] <= lo; end
        A_VDISP: begin sh_q[F_VDS] <= hi; sh_q[F_VDE] <= lo; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= '0;
      actc_q <= '0;
    end else if (load_i) begin
      act_q  <= sh_q;
      actc_q <= shc_q;
    end
  end

  assign fld_o = act_q;
  assign cfg_o = actc_q;

  // R8
  active_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(act_q) && $stable(actc_q)));
endmodule

// File: rtl/lcd_tg_axis.sv
module lcd_tg_axis #(
  parameter int CW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  input  logic [CW-1:0] total_i,
  output logic [CW-1:0] cnt_o,
  output logic          wrap_o
);
  logic [CW-1:0] cnt_q;
  logic [CW:0]   nxt;

  assign nxt    = {1'b0, cnt_q} + (CW+1)'(1);
  assign wrap_o = adv_i && (nxt >= {1'b0, total_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (wrap_o) cnt_q <= '0;
    else if (adv_i)  cnt_q <= nxt[CW-1:0];
  end

  assign cnt_o = cnt_q;

  // R2 R3
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !wrap_o) |=> (cnt_o == $past(cnt_o) + CW'(1)));
  // R2 R3
  cnt_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (cnt_o == '0));
  // R3
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(cnt_o));
  // R2
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == '0) || (cnt_o < total_i));
endmodule

// File: rtl/lcd_tg_window.sv
module lcd_tg_window #(
  parameter int CW = 10
) (
  input  logic [CW-1:0] pos_i,
  input  logic [CW-1:0] start_i,
  input  logic [CW-1:0] end_i,
  output logic          in_o
);
  // start inclusive, end exclusive
  assign in_o = (pos_i >= start_i) && (pos_i < end_i);
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
  import lcd_tg_pkg::*;
#(
  parameter int CW = 10,
  parameter int DW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DW-1:0]     wr_data_i,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              de_o,
  output logic              pclk_fall_o,
  output logic [CW-1:0]     hcnt_o,
  output logic [CW-1:0]     vcnt_o,
  output logic              line_o,
  output logic              frame_o
);
  localparam int NW = 4;

  logic [NF-1:0][CW-1:0] fld;
  logic [3:0]            cfg;
  logic [CW-1:0]         hcnt, vcnt;
  logic                  h_wrap, v_wrap;
  logic [NW-1:0][CW-1:0] w_pos, w_lo, w_hi;
  logic [NW-1:0]         w_in;

  lcd_tg_regs #(.CW(CW), .DW(DW)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .load_i(frame_o), .fld_o(fld), .cfg_o(cfg)
  );

  lcd_tg_axis #(.CW(CW)) u_h (
    .clk_i, .rst_ni, .adv_i(1'b1), .total_i(fld[F_HT]),
    .cnt_o(hcnt), .wrap_o(h_wrap)
  );

  lcd_tg_axis #(.CW(CW)) u_v (
    .clk_i, .rst_ni, .adv_i(h_wrap), .total_i(fld[F_VT]),
    .cnt_o(vcnt), .wrap_o(v_wrap)
  );

  // 0 hsync, 1 vsync, 2 h display, 3 v display
  always_comb begin
    w_pos[0] = hcnt; w_lo[0] = '0;         w_hi[0] = fld[F_HSE];
    w_pos[1] = vcnt; w_lo[1] = '0;         w_hi[1] = fld[F_VSE];
    w_pos[2] = hcnt; w_lo[2] = fld[F_HDS]; w_hi[2] = fld[F_HDE];
    w_pos[3] = vcnt; w_lo[3] = fld[F_VDS]; w_hi[3] = fld[F_VDE];
  end

  for (genvar i = 0; i < NW; i++) begin : g_win
    lcd_tg_window #(.CW(CW)) u_win (
      .pos_i(w_pos[i]), .start_i(w_lo[i]), .end_i(w_hi[i]), .in_o(w_in[i])
    );
  end

  assign hsync_o     = w_in[0] ^ cfg[C_HLOW];
  assign vsync_o     = w_in[1] ^ cfg[C_VLOW];
  assign de_o        = (w_in[2] & w_in[3]) ^ cfg[C_DELOW];
  assign pclk_fall_o = cfg[C_PFALL];
  assign hcnt_o      = hcnt;
  assign vcnt_o      = vcnt;
  assign line_o      = h_wrap;
  assign frame_o     = v_wrap;

  // R3
  frame_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_o |=> (hcnt_o == '0 && vcnt_o == '0));
  // R4
  hsync_lead_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hcnt_o == '0 && fld[F_HSE] != '0) |-> (hsync_o == !cfg[C_HLOW]));
  // R7
  pclk_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_o |=> $stable(pclk_fall_o));
  // R2
  line_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_o && !frame_o) |=> (hcnt_o == '0 && vcnt_o == $past(vcnt_o) + CW'(1)));
endmodule

// File: tb/sim_lcd_timing_gen.sv
module sim_lcd_timing_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        hsync, vsync, de, pclk_fall, line_s, frame_s;
  logic [9:0]  hcnt, vcnt;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  lcd_timing_gen u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .hsync_o(hsync), .vsync_o(vsync), .de_o(de),
    .pclk_fall_o(pclk_fall), .hcnt_o(hcnt), .vcnt_o(vcnt),
    .line_o(line_s), .frame_o(frame_s)
  );

  // configs: cfg word, hse, vse, ht, vt, hds, hde, vds, vde, ignored hsync start
  int c_cfg[3] = '{32'h000, 32'hF00, 32'h800};
  int c_hse[3] = '{2, 1, 0};
  int c_vse[3] = '{1, 2, 3};
  int c_ht [3] = '{12, 9, 7};
  int c_vt [3] = '{6, 5, 4};
  int c_hds[3] = '{4, 0, 2};
  int c_hde[3] = '{10, 9, 5};
  int c_vds[3] = '{2, 1, 0};
  int c_vde[3] = '{5, 4, 4};
  int c_hss[3] = '{5, 0, 7};

  task automatic check(string req, string nm, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, nm, act, exp);
    end
  endtask

  function automatic logic [31:0] word_of(int c, int idx, output logic [2:0] a);
    a = 3'(idx);
    case (idx)
      0: word_of = 32'(c_cfg[c]);
      1: word_of = 32'((c_hss[c] << 16) | c_hse[c]);
      2: word_of = 32'((9 << 16) | c_vse[c]);
      3: word_of = 32'((c_ht[c] << 16) | c_vt[c]);
      4: word_of = 32'((c_hds[c] << 16) | c_hde[c]);
      default: word_of = 32'((c_vds[c] << 16) | c_vde[c]);
    endcase
  endfunction

  task automatic drive_word(int c, int idx);
    logic [2:0] a;
    wr_data = word_of(c, idx, a);
    wr_addr = a;
    wr_en   = 1'b1;
  endtask

  // sweep one frame of config c; optionally write config nc mid-frame
  task automatic sweep(int c, bit wr, int nc, string tag);
    for (int t = 0; t < c_ht[c] * c_vt[c]; t++) begin
      int h = t % c_ht[c];
      int v = t / c_ht[c];
      int hl = (c_cfg[c] >> 11) & 1;
      int vl = (c_cfg[c] >> 8) & 1;
      int dl = (c_cfg[c] >> 9) & 1;
      int pf = (c_cfg[c] >> 10) & 1;
      int eh = (h < c_hse[c]) ? 1 : 0;
      int ev = (v < c_vse[c]) ? 1 : 0;
      int ed = (h >= c_hds[c] && h < c_hde[c] && v >= c_vds[c] && v < c_vde[c]) ? 1 : 0;
      int el = (h == c_ht[c] - 1) ? 1 : 0;
      int ef = (el == 1 && v == c_vt[c] - 1) ? 1 : 0;
      check({tag, " R2"}, "hcnt", int'(hcnt), h);
      check({tag, " R3"}, "vcnt", int'(vcnt), v);
      check({tag, " R2"}, "line", int'(line_s), el);
      check({tag, " R3"}, "frame", int'(frame_s), ef);
      check({tag, " R1 R4 R6"}, "hsync", int'(hsync), eh ^ hl);
      check({tag, " R4 R6"}, "vsync", int'(vsync), ev ^ vl);
      check({tag, " R5 R6"}, "de", int'(de), ed ^ dl);
      check({tag, " R7"}, "pclk_fall", int'(pclk_fall), pf);
      if (wr && t >= 3 && t < 9) drive_word(nc, t - 3);
      else wr_en = 1'b0;
      @(posedge clk);
      @(negedge clk);
    end
    wr_en = 1'b0;
  endtask

  initial begin
    #(5ns * 20000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    check("R9", "hcnt", int'(hcnt), 0);
    check("R9", "vcnt", int'(vcnt), 0);
    check("R9", "hsync", int'(hsync), 0);
    check("R9", "vsync", int'(vsync), 0);
    check("R9", "de", int'(de), 0);
    check("R9", "pclk_fall", int'(pclk_fall), 0);
    check("R9", "line", int'(line_s), 1);
    check("R9", "frame", int'(frame_s), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9", "frame_after_reset", int'(frame_s), 1);
    // load config 0, totals last
    for (int i = 0; i < 6; i++) begin
      if (i != 3) begin drive_word(0, i); @(posedge clk); @(negedge clk); end
    end
    drive_word(0, 3);
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
    while (frame_s !== 1'b1) @(negedge clk);
    @(posedge clk); @(negedge clk);
    sweep(0, 1'b0, 0, "A");
    // R8 write config 1 during a config-0 frame
    sweep(0, 1'b1, 1, "R8 A");
    sweep(1, 1'b0, 0, "R8 B");
    sweep(1, 1'b1, 2, "R8 B");
    sweep(2, 1'b0, 0, "R8 C");
    sweep(2, 1'b0, 0, "C");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule